// File: doc/BRIEF.md
# Configurable Microcontroller I/O Port

This block is one general-purpose port of a microcontroller companion device. Each pin carries three things: an output multiplexer with four sources, a tri-state driver, and an input capture cell. The output sources are the host's data-out bit, a latched address bit, a logic macrocell output and an external chip select. The driver is enabled when either a host direction bit or an externally supplied enable term is high. The capture cell can pass the pin straight through, act as a transparent latch, or act as an edge-triggered register. In latch or register mode it is strobed either by the address strobe or by a per-pin product term. The capture results feed the logic input bus.

The host programs three registers: data-out, direction and control. It reads them back over a single read path, which can also return the live pin levels, the capture outputs and the macrocell outputs. Some settings are fixed configuration and arrive on static inputs that the host cannot write: the alternate output source of each pin, each capture cell's mode and each capture cell's strobe choice. The logic-array equations are outside the block and arrive as plain input signals. The pins are modelled as separate in, out and enable vectors.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the data-out, direction and control registers read 0. Each `pin_oe` bit then equals the matching `oe_term` bit, and `pin_out` equals 0.
- R2: A write with `reg_wr` high to offset 1 (data-out), 2 (direction) or 3 (control) takes effect at the next rising clock edge. It does not show before that edge, and after it the register reads back the written byte.
- R3: When control bit i is 0, pin i outputs data-out bit i. When control bit i is 1, pin i outputs the source named by `cfg_src[2i+1:2i]`: 0 selects data-out, 1 the latched address, 2 the macrocell output and 3 the chip select.
- R4: `pin_oe[i]` is the OR of direction bit i and `oe_term[i]`.
- R5: A read at offset 0 returns `pin_in` combinationally.
- R6: The capture mode of pin i is `cfg_cap_mode[2i+1:2i]`. Values 0 and 3 are direct mode, where `cap_out[i]` follows `pin_in[i]` combinationally.
- R7: Latch mode is mode value 1. While the strobe is high, `cap_out[i]` follows `pin_in[i]`. While it is low, `cap_out[i]` holds the pin level sampled at the last clock edge at which the strobe was high.
- R8: Register mode is mode value 2. The cell samples the pin at a clock edge where the strobe is high and was low at the previous edge. `cap_out[i]` holds that value until the next such edge.
- R9: `cfg_cap_clk[i]` = 0 strobes cell i with `ale`, and 1 strobes it with `cap_term[i]`.
- R10: Offset 4 reads `cap_out` and offset 5 reads `mcell`. Offsets 6 and 7 read 0. Reads change no state.
- R11: Writes to offsets 0, 4, 5, 6 and 7 are ignored, and every host register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Levels present at the pins |
| pin_out | output | WIDTH | Values driven onto the pins |
| pin_oe | output | WIDTH | Driver enables, 1 = drive |
| oe_term | input | WIDTH | External enable product terms, 0 where undefined |
| lat_addr | input | WIDTH | Latched address bits |
| mcell | input | WIDTH | Logic macrocell outputs |
| chip_sel | input | WIDTH | External chip-select signals |
| ale | input | 1 | Address strobe |
| cap_term | input | WIDTH | Per-pin capture strobe product terms |
| cfg_src | input | 2*WIDTH | Fixed alternate output source, 2 bits per pin |
| cfg_cap_mode | input | 2*WIDTH | Fixed capture mode, 2 bits per pin |
| cfg_cap_clk | input | WIDTH | Fixed capture strobe choice per pin |
| cap_out | output | WIDTH | Capture cell outputs to the logic input bus |

## Verification
Some results are combinational: the read data, the pin output mux, the driver enable, and the direct and transparent-latch capture outputs. The bench checks each of these one nanosecond after it drives the inputs at a falling edge, within the same cycle. Register writes and register-mode captures land one rising edge after the falling edge that set up the stimulus. For these the bench waits for the next falling edge and also checks the old value before that edge. A latch's held value is checked after the strobe drops, using the pin level from the last rising edge at which the strobe was high.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_PINS  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DOUT  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_CAP   = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_MCELL = 3'd5;

    typedef enum logic [1:0] {
        SRC_DOUT  = 2'd0,
        SRC_ADDR  = 2'd1,
        SRC_MCELL = 2'd2,
        SRC_CSEL  = 2'd3
    } out_src_e;

    typedef enum logic [1:0] {
        CAP_DIRECT  = 2'd0,
        CAP_LATCH   = 2'd1,
        CAP_REG     = 2'd2,
        CAP_DIRECT2 = 2'd3
    } cap_mode_e;

    typedef struct packed {
        logic hold;
        logic prev;
    } cap_state_t;

endpackage

// File: rtl/io_out_mux.sv
module io_out_mux
    import cfg_io_port_pkg::*;
(
    input  logic       use_alt,
    input  logic [1:0] alt_sel,
    input  logic       dout,
    input  logic       addr,
    input  logic       mc,
    input  logic       cs,
    output logic       y
);
    always_comb begin
        y = dout;
        if (use_alt) begin
            unique case (out_src_e'(alt_sel))
                SRC_DOUT:  y = dout;
                SRC_ADDR:  y = addr;
                SRC_MCELL: y = mc;
                SRC_CSEL:  y = cs;
            endcase
        end
    end
endmodule

// File: rtl/io_capture_cell.sv
module io_capture_cell
    import cfg_io_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       strobe,
    input  logic       pin,
    output logic       q
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
        unique case (cap_mode_e'(mode))
            CAP_LATCH:   if (strobe) st_d.hold = pin;
            CAP_REG:     if (strobe && !st_q.prev) st_d.hold = pin;
            CAP_DIRECT,
            CAP_DIRECT2: st_d.hold = st_q.hold;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (cap_mode_e'(mode))
            CAP_LATCH:   q = strobe ? pin : st_q.hold;
            CAP_REG:     q = st_q.hold;
            CAP_DIRECT,
            CAP_DIRECT2: q = pin;
        endcase
    end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cfg_io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WIDTH-1:0]     reg_wdata,
    output logic [WIDTH-1:0]     reg_rdata,
    input  logic [WIDTH-1:0]     pin_in,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe,
    input  logic [WIDTH-1:0]     oe_term,
    input  logic [WIDTH-1:0]     lat_addr,
    input  logic [WIDTH-1:0]     mcell,
    input  logic [WIDTH-1:0]     chip_sel,
    input  logic                 ale,
    input  logic [WIDTH-1:0]     cap_term,
    input  logic [2*WIDTH-1:0]   cfg_src,
    input  logic [2*WIDTH-1:0]   cfg_cap_mode,
    input  logic [WIDTH-1:0]     cfg_cap_clk,
    output logic [WIDTH-1:0]     cap_out
);
    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] ctrl;
    } host_regs_t;

    host_regs_t r_d, r_q;
    logic [WIDTH-1:0] dout_q, dir_q, ctrl_q;
    logic [WIDTH-1:0] strobe;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                OFF_DOUT: r_d.dout = reg_wdata;
                OFF_DIR:  r_d.dir  = reg_wdata;
                OFF_CTRL: r_d.ctrl = reg_wdata;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout_q = r_q.dout;
    assign dir_q  = r_q.dir;
    assign ctrl_q = r_q.ctrl;
    assign pin_oe = dir_q | oe_term;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign strobe[i] = cfg_cap_clk[i] ? cap_term[i] : ale;

        io_out_mux u_mux (
            .use_alt (ctrl_q[i]),
            .alt_sel (cfg_src[2*i +: 2]),
            .dout    (dout_q[i]),
            .addr    (lat_addr[i]),
            .mc      (mcell[i]),
            .cs      (chip_sel[i]),
            .y       (pin_out[i])
        );

        io_capture_cell u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (cfg_cap_mode[2*i +: 2]),
            .strobe (strobe[i]),
            .pin    (pin_in[i]),
            .q      (cap_out[i])
        );
    end

    always_comb begin
        case (reg_addr)
            OFF_PINS:  reg_rdata = pin_in;
            OFF_DOUT:  reg_rdata = dout_q;
            OFF_DIR:   reg_rdata = dir_q;
            OFF_CTRL:  reg_rdata = ctrl_q;
            OFF_CAP:   reg_rdata = cap_out;
            OFF_MCELL: reg_rdata = mcell;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk
    import cfg_io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [WIDTH-1:0]     reg_wdata,
    input logic [WIDTH-1:0]     reg_rdata,
    input logic [WIDTH-1:0]     pin_in,
    input logic [WIDTH-1:0]     pin_out,
    input logic [WIDTH-1:0]     pin_oe,
    input logic [WIDTH-1:0]     oe_term,
    input logic [WIDTH-1:0]     cap_out,
    input logic [2*WIDTH-1:0]   cfg_cap_mode,
    input logic [WIDTH-1:0]     dout_q,
    input logic [WIDTH-1:0]     ctrl_q
);
    a_r4_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_DIR) |=> (pin_oe == ($past(reg_wdata) | oe_term)));

    a_r2_dout_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_DOUT) ##1 (reg_addr == OFF_DOUT)
        |-> (reg_rdata == $past(reg_wdata)));

    a_r5_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_PINS) |-> (reg_rdata == pin_in));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd6 || reg_addr == 3'd7) |-> (reg_rdata == '0));

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        a_r3_dout_source: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[i] |-> (pin_out[i] == dout_q[i]));

        a_r6_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_cap_mode[2*i +: 2] == 2'd0) |-> (cap_out[i] == pin_in[i]));
    end
endmodule

bind cfg_io_port cfg_io_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .oe_term      (oe_term),
    .cap_out      (cap_out),
    .cfg_cap_mode (cfg_cap_mode),
    .dout_q       (dout_q),
    .ctrl_q       (ctrl_q)
);

// File: tb/tb_cfg_io_port.sv
module tb_cfg_io_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   reg_addr;
    logic         reg_wr;
    logic [W-1:0] reg_wdata, reg_rdata;
    logic [W-1:0] pin_in, pin_out, pin_oe, oe_term;
    logic [W-1:0] lat_addr, mcell, chip_sel, cap_term, cfg_cap_clk, cap_out;
    logic         ale;
    logic [2*W-1:0] cfg_src, cfg_cap_mode;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cfg_io_port #(.WIDTH(W)) dut (.*);

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic t_reset_state();
        oe_term = 8'h81;
        do_reset();
        #1;
        rd_check("R1 dout after reset", 3'd1, 8'h00);
        rd_check("R1 dir after reset",  3'd2, 8'h00);
        rd_check("R1 ctrl after reset", 3'd3, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h81);
        check("R1 pin_out after reset", pin_out, 8'h00);
        oe_term = 8'h00;
    endtask

    task automatic t_write_readback();
        @(negedge clk);
        reg_addr = 3'd1; reg_wr = 1'b1; reg_wdata = 8'hA5;
        #1;
        check("R2 dout not yet written", reg_rdata, 8'h00);
        @(negedge clk);
        reg_wr = 1'b0;
        rd_check("R2 dout readback", 3'd1, 8'hA5);
        wr(3'd2, 8'h5A);
        rd_check("R2 dir readback", 3'd2, 8'h5A);
        wr(3'd3, 8'hC3);
        rd_check("R2 ctrl readback", 3'd3, 8'hC3);
    endtask

    task automatic t_ignored_writes();
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rd_check("R11 dout kept", 3'd1, 8'hA5);
        rd_check("R11 dir kept",  3'd2, 8'h5A);
        rd_check("R11 ctrl kept", 3'd3, 8'hC3);
    endtask

    task automatic t_out_mux();
        logic [W-1:0] e;
        cfg_src = 16'hE4E4;
        lat_addr = 8'h33; mcell = 8'h55; chip_sel = 8'hF0;
        wr(3'd1, 8'h0F);
        foreach (e[i]) e[i] = 1'b0;
        for (int c = 0; c < 3; c++) begin
            logic [W-1:0] cv;
            cv = (c == 0) ? 8'hFF : (c == 1) ? 8'h00 : 8'hF0;
            wr(3'd3, cv);
            #1;
            for (int i = 0; i < W; i++) begin
                if (!cv[i]) e[i] = 1'b0 ^ 8'h0F >> i & 1'b1;
                else case (i % 4)
                    0: e[i] = (8'h0F >> i) & 1'b1;
                    1: e[i] = lat_addr[i];
                    2: e[i] = mcell[i];
                    default: e[i] = chip_sel[i];
                endcase
            end
            check("R3 output source select", pin_out, e);
        end
    endtask

    task automatic t_oe();
        wr(3'd2, 8'h3C);
        oe_term = 8'h81;
        #1;
        check("R4 oe with term", pin_oe, 8'hBD);
        oe_term = 8'h00;
        #1;
        check("R4 oe dir only", pin_oe, 8'h3C);
        wr(3'd2, 8'h00);
        oe_term = 8'h81;
        #1;
        check("R4 oe term only", pin_oe, 8'h81);
        oe_term = 8'h00;
    endtask

    task automatic t_reads();
        @(negedge clk);
        pin_in = 8'h6B;
        rd_check("R5 pin read", 3'd0, 8'h6B);
        pin_in = 8'h94;
        rd_check("R5 pin read change", 3'd0, 8'h94);
        mcell = 8'h2E;
        rd_check("R10 mcell read", 3'd5, 8'h2E);
        rd_check("R10 offset 6 zero", 3'd6, 8'h00);
        rd_check("R10 offset 7 zero", 3'd7, 8'h00);
        @(negedge clk);
        rd_check("R10 no side effect dout", 3'd1, 8'hA5);
    endtask

    task automatic t_direct();
        cfg_cap_mode = 16'h0000;
        @(negedge clk);
        pin_in = 8'hC6;
        #1;
        check("R6 direct follow", cap_out, 8'hC6);
        cfg_cap_mode = 16'hFFFF;
        pin_in = 8'h39;
        #1;
        check("R6 mode 3 direct", cap_out, 8'h39);
        rd_check("R10 capture readback", 3'd4, 8'h39);
    endtask

    task automatic t_latch();
        do_reset();
        cfg_cap_mode = 16'h5555; cfg_cap_clk = 8'h00;
        ale = 1'b0; pin_in = 8'h5A;
        #1;
        check("R7 latch closed after reset", cap_out, 8'h00);
        @(negedge clk);
        ale = 1'b1;
        #1;
        check("R7 latch transparent", cap_out, 8'h5A);
        @(negedge clk);
        pin_in = 8'h77;
        #1;
        check("R7 latch follows", cap_out, 8'h77);
        @(negedge clk);
        ale = 1'b0; pin_in = 8'hFF;
        #1;
        check("R7 latch holds", cap_out, 8'h77);
        @(negedge clk);
        check("R7 latch still holds", cap_out, 8'h77);
    endtask

    task automatic t_register();
        do_reset();
        cfg_cap_mode = 16'hAAAA; cfg_cap_clk = 8'h00;
        ale = 1'b0; pin_in = 8'hA5;
        @(negedge clk);
        ale = 1'b1;
        #1;
        check("R8 before strobe edge", cap_out, 8'h00);
        @(negedge clk);
        #1;
        check("R8 captured on rise", cap_out, 8'hA5);
        pin_in = 8'h3C;
        @(negedge clk);
        #1;
        check("R8 no capture while high", cap_out, 8'hA5);
        ale = 1'b0; pin_in = 8'h11;
        @(negedge clk);
        #1;
        check("R8 holds while low", cap_out, 8'hA5);
        ale = 1'b1;
        @(negedge clk);
        #1;
        check("R8 second capture", cap_out, 8'h11);
        ale = 1'b0;
    endtask

    task automatic t_strobe_select();
        do_reset();
        cfg_cap_mode = 16'hAAAA; cfg_cap_clk = 8'hFF;
        cap_term = 8'h00; pin_in = 8'h99;
        @(negedge clk);
        ale = 1'b1;
        @(negedge clk);
        #1;
        check("R9 ale ignored with term select", cap_out, 8'h00);
        cap_term = 8'h0F;
        @(negedge clk);
        #1;
        check("R9 term strobes low nibble", cap_out, 8'h09);
        ale = 1'b0; cap_term = 8'h00;
    endtask

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        pin_in = '0; oe_term = '0; lat_addr = '0; mcell = '0; chip_sel = '0;
        ale = 1'b0; cap_term = '0; cfg_src = '0; cfg_cap_mode = '0; cfg_cap_clk = '0;
        t_reset_state();
        t_write_readback();
        t_ignored_writes();
        t_out_mux();
        t_oe();
        wr(3'd1, 8'hA5);
        t_reads();
        t_direct();
        t_latch();
        t_register();
        t_strobe_select();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule